// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block computes the memory address that a load instruction refers to. A request strobe arrives with a two-bit mode code and three operands: a 16-bit signed displacement taken from the instruction, a base register value and an index register value. A two-bit scale select goes with them. The block combines these operands as the mode requires. One clock edge later it presents the result on a registered address output, together with a valid flag.

Four modes are supported:

- **Absolute:** the address is the displacement alone.
- **Register:** the address is the base register alone.
- **Register plus offset:** the address is the base plus the displacement.
- **Scaled indexed:** the address is the base plus the displacement plus the index multiplied by 1, 2, 4 or 8.

All arithmetic is 32 bits wide and wraps silently. Reading the register file and performing the memory access are left to neighbouring logic.

Top module: `eff_addr_gen`

## Requirements
- R1: While rst_ni is low, addr_o is 0 and valid_o is 0.
- R2: valid_o is 1 in the cycle after a clock edge at which req_i is 1, and 0 in the cycle after an edge at which req_i is 0.
- R3: After an edge at which req_i is 0, addr_o keeps its previous value whatever the other inputs do.
- R4: mode_i = 2'b00 (absolute) gives addr_o equal to the sign-extended displacement; base_i and index_i have no effect.
- R5: mode_i = 2'b01 (register) gives addr_o equal to base_i; disp_i and index_i have no effect.
- R6: mode_i = 2'b10 (register plus offset) gives addr_o equal to base_i plus the sign-extended displacement; index_i has no effect.
- R7: mode_i = 2'b11 (scaled indexed) gives addr_o equal to base_i plus the sign-extended displacement plus index_i shifted left by scale_i. The values 0, 1, 2 and 3 of scale_i select factors 1, 2, 4 and 8, and index bits shifted past bit 31 are dropped.
- R8: All sums wrap modulo 2^32, and no overflow is reported.
- R9: disp_i is two's complement; bit 15 set makes it negative, copied into bits 31..16 before addition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe; operands are sampled when it is high |
| mode_i | input | 2 | Addressing mode code |
| disp_i | input | 16 | Signed displacement from the instruction |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| scale_i | input | 2 | Index scale select (shift by 0..3) |
| addr_o | output | 32 | Registered effective address |
| valid_o | output | 1 | Registered valid flag |

## Verification
Every mode is driven with a nonzero base and a nonzero index even where the mode must ignore them, so that a wrong operand selection shows up as a changed address. The scaled indexed mode is applied with the same operands under all four scale values, which separates an off-by-one shift from a correct one. Displacements with bit 15 set are paired with small bases, exposing a missing sign extension. Operand sets whose true sum exceeds 32 bits, and an index with high bits set under the largest shift, show whether carries and shifted-out bits are dropped.

// File: rtl/eff_addr_pkg.sv
package eff_addr_pkg;
  localparam int ADDR_W  = 32;
  localparam int DISP_W  = 16;
  localparam int SCL_W   = 2;

  typedef enum logic [1:0] {
    MODE_ABS         = 2'b00,
    MODE_REG         = 2'b01,
    MODE_REG_OFS     = 2'b10,
    MODE_REG_OFS_IDX = 2'b11
  } ea_mode_e;
endpackage

// File: rtl/eff_addr_sext.sv
module eff_addr_sext #(
  parameter int DISP_W = 16,
  parameter int ADDR_W = 32
) (
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] sdisp_o
);
  localparam int EXT_W = ADDR_W - DISP_W;

  generate
    if (EXT_W > 0) begin : g_ext
      assign sdisp_o = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    end else begin : g_trunc
      assign sdisp_o = disp_i[ADDR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/eff_addr_scale.sv
module eff_addr_scale #(
  parameter int ADDR_W = 32,
  parameter int SCL_W  = 2
) (
  input  logic [ADDR_W-1:0] idx_i,
  input  logic [SCL_W-1:0]  scl_i,
  output logic [ADDR_W-1:0] scaled_o
);
  localparam int NUM_SCL = 1 << SCL_W;

  logic [ADDR_W-1:0] cand [NUM_SCL];

  // one pre-shifted copy per scale factor, then a single mux level
  for (genvar g = 0; g < NUM_SCL; g++) begin : g_shift
    assign cand[g] = idx_i << g;
  end

  assign scaled_o = cand[scl_i];
endmodule

// File: rtl/eff_addr_opsel.sv
module eff_addr_opsel
  import eff_addr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  ea_mode_e          mode_i,
  input  logic [ADDR_W-1:0] sdisp_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] scaled_i,
  output logic [ADDR_W-1:0] op_disp_o,
  output logic [ADDR_W-1:0] op_base_o,
  output logic [ADDR_W-1:0] op_idx_o
);
  // unused terms are forced to zero so one 3-input adder serves all modes
  always_comb begin
    op_disp_o = '0;
    op_base_o = '0;
    op_idx_o  = '0;
    unique case (mode_i)
      MODE_ABS: begin
        op_disp_o = sdisp_i;
      end
      MODE_REG: begin
        op_base_o = base_i;
      end
      MODE_REG_OFS: begin
        op_disp_o = sdisp_i;
        op_base_o = base_i;
      end
      MODE_REG_OFS_IDX: begin
        op_disp_o = sdisp_i;
        op_base_o = base_i;
        op_idx_o  = scaled_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import eff_addr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DISP_W,
  parameter int SW = SCL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] disp_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] index_i,
  input  logic [SW-1:0] scale_i,
  output logic [AW-1:0] addr_o,
  output logic          valid_o
);
  localparam int EXT_W = AW - DW;

  logic [AW-1:0] sdisp;
  logic [AW-1:0] scaled;
  logic [AW-1:0] op_disp, op_base, op_idx;
  logic [AW-1:0] ea_sum;
  ea_mode_e      mode;

  assign mode = ea_mode_e'(mode_i);

  eff_addr_sext #(.DISP_W(DW), .ADDR_W(AW)) u_sext (
    .disp_i  (disp_i),
    .sdisp_o (sdisp)
  );

  eff_addr_scale #(.ADDR_W(AW), .SCL_W(SW)) u_scale (
    .idx_i    (index_i),
    .scl_i    (scale_i),
    .scaled_o (scaled)
  );

  eff_addr_opsel #(.ADDR_W(AW)) u_opsel (
    .mode_i    (mode),
    .sdisp_i   (sdisp),
    .base_i    (base_i),
    .scaled_i  (scaled),
    .op_disp_o (op_disp),
    .op_base_o (op_base),
    .op_idx_o  (op_idx)
  );

  // modulo 2^AW, carry out discarded
  assign ea_sum = op_base + op_disp + op_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= req_i;
      if (req_i) addr_o <= ea_sum;
    end
  end

  // R1
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r1: assert (addr_o == '0 && !valid_o)
        else $error("R1: outputs not cleared in reset");
    end
  end

  p_valid_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);

  p_valid_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(addr_o));

  p_abs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == 2'b00) |=>
      (addr_o[DW-1:0] == $past(disp_i) &&
       addr_o[AW-1:DW] == {EXT_W{$past(disp_i[DW-1])}}));

  p_reg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == 2'b01) |=> addr_o == $past(base_i));

  p_ofs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == 2'b10) |=>
      (addr_o - $past(base_i)) == {{EXT_W{$past(disp_i[DW-1])}}, $past(disp_i)});

  p_unit_scale_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mode_i == 2'b11 && scale_i == '0) |=>
      (addr_o - $past(base_i) - $past(index_i)) ==
        {{EXT_W{$past(disp_i[DW-1])}}, $past(disp_i)});
endmodule

// File: tb/eff_addr_gen_bench.sv
module eff_addr_gen_bench;
  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  scale;
    logic [15:0] disp;
    logic [31:0] base;
    logic [31:0] index;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 2'd0, 16'h1234, 32'hDEAD_BEEF, 32'h0000_0005, 32'h0000_1234}, // R4
    '{2'b00, 2'd3, 16'h8000, 32'h1111_1111, 32'h2222_2222, 32'hFFFF_8000}, // R4 R9
    '{2'b01, 2'd2, 16'h7FFF, 32'h1000_0040, 32'hFFFF_FFFF, 32'h1000_0040}, // R5
    '{2'b10, 2'd1, 16'h0010, 32'h0000_1000, 32'h0000_0123, 32'h0000_1010}, // R6
    '{2'b10, 2'd0, 16'hFFFC, 32'h0000_1000, 32'h0000_0077, 32'h0000_0FFC}, // R6 R9
    '{2'b11, 2'd0, 16'h0004, 32'h2000_0000, 32'h0000_0010, 32'h2000_0014}, // R7 x1
    '{2'b11, 2'd1, 16'h0004, 32'h2000_0000, 32'h0000_0010, 32'h2000_0024}, // R7 x2
    '{2'b11, 2'd2, 16'h0004, 32'h2000_0000, 32'h0000_0010, 32'h2000_0044}, // R7 x4
    '{2'b11, 2'd3, 16'h0004, 32'h2000_0000, 32'h0000_0010, 32'h2000_0084}, // R7 x8
    '{2'b11, 2'd3, 16'h8000, 32'h0000_0000, 32'h0000_1000, 32'h0000_0000}, // R8 R9
    '{2'b10, 2'd0, 16'h0010, 32'hFFFF_FFF8, 32'h0000_0000, 32'h0000_0008}, // R8
    '{2'b11, 2'd3, 16'h0000, 32'h0000_0000, 32'hF000_0001, 32'h8000_0008}  // R7 R8
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [15:0] disp_i = '0;
  logic [31:0] base_i = '0;
  logic [31:0] index_i = '0;
  logic [1:0]  scale_i = '0;
  logic [31:0] addr_o;
  logic        valid_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  eff_addr_gen u_eff_addr_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .mode_i  (mode_i),
    .disp_i  (disp_i),
    .base_i  (base_i),
    .index_i (index_i),
    .scale_i (scale_i),
    .addr_o  (addr_o),
    .valid_o (valid_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic [1:0] m, input logic [1:0] s,
                       input logic [15:0] d, input logic [31:0] b, input logic [31:0] x);
    req_i = r; mode_i = m; scale_i = s; disp_i = d; base_i = b; index_i = x;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 addr in reset", addr_o, 32'h0);
    check("R1 valid in reset", {31'b0, valid_o}, 32'h0);
    rst_ni = 1'b1;

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(1'b1, VECS[i].mode, VECS[i].scale, VECS[i].disp, VECS[i].base, VECS[i].index);
      @(negedge clk_i);
      check($sformatf("R4-9 vec %0d addr", i), addr_o, VECS[i].exp);
      check("R2 valid after req", {31'b0, valid_o}, 32'h1);
    end

    // R2/R3: drop req, scramble inputs, address holds
    drive(1'b0, 2'b01, 2'd1, 16'h5555, 32'hAAAA_AAAA, 32'h1234_5678);
    @(negedge clk_i);
    check("R2 valid low without req", {31'b0, valid_o}, 32'h0);
    check("R3 addr held", addr_o, 32'h8000_0008);
    drive(1'b0, 2'b11, 2'd3, 16'hFFFF, 32'h0BAD_F00D, 32'hFFFF_FFFF);
    @(negedge clk_i);
    check("R3 addr held 2", addr_o, 32'h8000_0008);

    // R5: displacement and index ignored in register mode
    drive(1'b1, 2'b01, 2'd3, 16'h8001, 32'h0000_0ABC, 32'h7777_7777);
    @(negedge clk_i);
    check("R5 register ignores disp/index", addr_o, 32'h0000_0ABC);

    // R4: base and index ignored in absolute mode
    drive(1'b1, 2'b00, 2'd2, 16'h0042, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    @(negedge clk_i);
    check("R4 absolute ignores base/index", addr_o, 32'h0000_0042);

    // R2: back-to-back requests, then gap
    drive(1'b1, 2'b10, 2'd0, 16'hFFFF, 32'h0000_0000, 32'h0);
    @(negedge clk_i);
    check("R9 minus one", addr_o, 32'hFFFF_FFFF);
    drive(1'b0, 2'b00, 2'd0, 16'h0, 32'h0, 32'h0);
    @(negedge clk_i);
    check("R2 single-cycle valid", {31'b0, valid_o}, 32'h0);

    // R1: reset mid-operation
    drive(1'b1, 2'b01, 2'd0, 16'h0, 32'h1234_0000, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1 async clear addr", addr_o, 32'h0);
    check("R1 async clear valid", {31'b0, valid_o}, 32'h0);
    req_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule